// File: doc/BRIEF.md
# Subword Shuffle Unit

This block reorders 16-bit lanes of 64-bit operands in a single registered stage, without any memory access. It offers three rearrangements. A halfword interleave merges alternating 16-bit lanes of two sources. A word interleave joins one 32-bit half of each source. A lane permute fills each result lane with any lane of the first source, and the same lane may be used more than once.

A caller presents both operands, an operation code, a left/right choice and a permutation selector together with `in_valid`. Exactly one clock edge later the result appears on `result`, with `out_valid` high. Between transactions the result register keeps its last value. In the descriptions below, lanes are named 1 to 4 from the most significant end: lane 1 is bits 63:48 and lane 4 is bits 15:0. Selector fields are indexed by bit position: field k is `lane_sel[2k+1:2k]` and controls result bits `16k+15:16k`.

Top module: `subword_shuffle`

## Requirements
- R1: While `rst` is high, and at the first edge after it, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals the value `in_valid` had at the previous clock edge, so every accepted operation has a latency of exactly one cycle.
- R3: Operation code 2'b00 with `take_left`=1 yields lanes {A1, B1, A3, B3}, from most to least significant.
- R4: Operation code 2'b00 with `take_left`=0 yields lanes {A2, B2, A4, B4}.
- R5: Operation code 2'b01 with `take_left`=1 yields {A[63:32], B[63:32]}.
- R6: Operation code 2'b01 with `take_left`=0 yields {A[31:0], B[31:0]}.
- R7: Operation code 2'b10 sets result bits 16k+15:16k to A bits 16j+15:16j, where j = `lane_sel[2k+1:2k]`. Repeated indices are allowed, so all 256 selector values are legal.
- R8: Under operation code 2'b10, `src_b` and `take_left` have no effect on the result.
- R9: While `in_valid` is low, `result` keeps its value, whatever the other inputs do.
- R10: Operation code 2'b11 yields an all-zero result.
- R11: Under operation codes 2'b00 and 2'b01, `lane_sel` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request for this cycle |
| op_sel | input | 2 | 00 halfword interleave, 01 word interleave, 10 lane permute, 11 zero |
| take_left | input | 1 | 1 selects the upper (left) pattern of an interleave |
| lane_sel | input | 8 | Four 2-bit source-lane indices for the permute |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| out_valid | output | 1 | Result register was loaded on the last edge |
| result | output | 64 | Registered rearranged value |

## Verification
Because the block holds only the result register and the valid flag, any fault shows up at the ports on the cycle right after the offending request. A swapped lane, a wrong selector field or a wrong interleave phase therefore appears in the very next `result`. The bench sweeps all 256 permute selectors with distinct lane contents, so a lane that is misrouted even once shows up as an unexpected 16-bit value. Idle cycles with changing inputs would expose a register that loads without a request, and a wrong valid flag would show up as a result arriving one cycle early or late.

// File: rtl/subword_shuffle_pkg.sv
`timescale 1ns/1ps
package subword_shuffle_pkg;
  typedef enum logic [1:0] {
    OP_HALF_MIX = 2'b00,
    OP_WORD_MIX = 2'b01,
    OP_LANE_PERM = 2'b10,
    OP_ZERO = 2'b11
  } shuf_op_e;
endpackage

// File: rtl/sw_half_mix.sv
`timescale 1ns/1ps
// Interleaves LANE_W-bit lanes of two sources. Lane pairs counted from the
// most significant end: even result position takes A, odd takes B.
module sw_half_mix #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int W = LANE_W * LANES
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         left,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int MSB_POS = LANES - 1 - i;     // position from the top
    localparam int PAIR    = MSB_POS / 2;
    localparam int FROM_B  = MSB_POS % 2;
    localparam int SRC_L   = LANES - 1 - 2 * PAIR; // upper lane of pair
    localparam int SRC_R   = LANES - 2 - 2 * PAIR; // lower lane of pair
    logic [W-1:0] src;
    assign src = (FROM_B != 0) ? b : a;
    assign y[i*LANE_W +: LANE_W] = left ? src[SRC_L*LANE_W +: LANE_W]
                                        : src[SRC_R*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/sw_word_mix.sv
`timescale 1ns/1ps
// Joins one half of A (upper part of the result) with the same half of B.
module sw_word_mix #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int W    = LANE_W * LANES,
  localparam int HALF = W / 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         left,
  output logic [W-1:0] y
);
  always_comb begin
    if (left) y = {a[W-1:HALF], b[W-1:HALF]};
    else      y = {a[HALF-1:0], b[HALF-1:0]};
  end
endmodule

// File: rtl/sw_lane_perm.sv
`timescale 1ns/1ps
// Each result lane k copies the source lane named by selector field k.
module sw_lane_perm #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int W     = LANE_W * LANES,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [W-1:0]           a,
  input  logic [LANES*SEL_W-1:0] sel,
  output logic [W-1:0]           y
);
  for (genvar k = 0; k < LANES; k++) begin : g_dst
    logic [SEL_W-1:0] idx;
    assign idx = sel[k*SEL_W +: SEL_W];
    always_comb begin
      y[k*LANE_W +: LANE_W] = '0;
      for (int j = 0; j < LANES; j++) begin
        if (idx == SEL_W'(j)) y[k*LANE_W +: LANE_W] = a[j*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/subword_shuffle.sv
`timescale 1ns/1ps
module subword_shuffle
  import subword_shuffle_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int W     = LANE_W * LANES,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [1:0]             op_sel,
  input  logic                   take_left,
  input  logic [LANES*SEL_W-1:0] lane_sel,
  input  logic [W-1:0]           src_a,
  input  logic [W-1:0]           src_b,
  output logic                   out_valid,
  output logic [W-1:0]           result
);
  logic [W-1:0] half_y, word_y, perm_y, next_y;
  shuf_op_e     op;

  assign op = shuf_op_e'(op_sel);

  sw_half_mix #(.LANE_W(LANE_W), .LANES(LANES)) u_half (
    .a(src_a), .b(src_b), .left(take_left), .y(half_y));

  sw_word_mix #(.LANE_W(LANE_W), .LANES(LANES)) u_word (
    .a(src_a), .b(src_b), .left(take_left), .y(word_y));

  sw_lane_perm #(.LANE_W(LANE_W), .LANES(LANES)) u_perm (
    .a(src_a), .sel(lane_sel), .y(perm_y));

  always_comb begin
    unique case (op)
      OP_HALF_MIX:  next_y = half_y;
      OP_WORD_MIX:  next_y = word_y;
      OP_LANE_PERM: next_y = perm_y;
      default:      next_y = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_y;
    end
  end
endmodule

// File: rtl/subword_shuffle_chk.sv
`timescale 1ns/1ps
module subword_shuffle_chk #(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  localparam int W     = LANE_W * LANES,
  localparam int HALF  = W / 2,
  localparam int SEL_W = $clog2(LANES)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [1:0]             op_sel,
  input logic                   take_left,
  input logic [LANES*SEL_W-1:0] lane_sel,
  input logic [W-1:0]           src_a,
  input logic [W-1:0]           src_b,
  input logic                   out_valid,
  input logic [W-1:0]           result
);
  function automatic logic [LANE_W-1:0] lane_of(logic [W-1:0] v, logic [SEL_W-1:0] idx);
    return v[int'(idx)*LANE_W +: LANE_W];
  endfunction

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  a_r3_half_left_top: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b00 && take_left) |=>
      (result[W-1 -: LANE_W] == $past(src_a[W-1 -: LANE_W]) &&
       result[W-1-LANE_W -: LANE_W] == $past(src_b[W-1 -: LANE_W])));

  a_r4_half_right_low: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b00 && !take_left) |=>
      (result[2*LANE_W-1 -: LANE_W] == $past(src_a[LANE_W-1:0]) &&
       result[LANE_W-1:0] == $past(src_b[LANE_W-1:0])));

  a_r5_word_left: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b01 && take_left) |=>
      result == {$past(src_a[W-1:HALF]), $past(src_b[W-1:HALF])});

  a_r6_word_right: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b01 && !take_left) |=>
      result == {$past(src_a[HALF-1:0]), $past(src_b[HALF-1:0])});

  a_r10_zero_code: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b11) |=> result == '0);

  for (genvar k = 0; k < LANES; k++) begin : g_perm_chk
    a_r7_perm_lane: assert property (@(posedge clk) disable iff (rst)
      (in_valid && op_sel == 2'b10) |=>
        result[k*LANE_W +: LANE_W] ==
          lane_of($past(src_a), $past(lane_sel[k*SEL_W +: SEL_W])));
  end
endmodule

bind subword_shuffle subword_shuffle_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
  .take_left(take_left), .lane_sel(lane_sel), .src_a(src_a), .src_b(src_b),
  .out_valid(out_valid), .result(result));

// File: tb/test_subword_shuffle.sv
`timescale 1ns/1ps
module test_subword_shuffle;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic        take_left = 1'b0;
  logic [7:0]  lane_sel = 8'h00;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic iv_d = 1'b0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  subword_shuffle i_subword_shuffle (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .take_left(take_left), .lane_sel(lane_sel), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .result(result));

  // lane n counted from the top: 1 = bits 63:48, 4 = bits 15:0
  function automatic logic [15:0] hw(logic [63:0] v, int n);
    return v[64 - 16*n +: 16];
  endfunction

  function automatic logic [63:0] model(logic [1:0] op, logic lft, logic [7:0] sel,
                                        logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    case (op)
      2'b00: r = lft ? {hw(a,1), hw(b,1), hw(a,3), hw(b,3)}
                     : {hw(a,2), hw(b,2), hw(a,4), hw(b,4)};
      2'b01: r = lft ? {hw(a,1), hw(a,2), hw(b,1), hw(b,2)}
                     : {hw(a,3), hw(a,4), hw(b,3), hw(b,4)};
      2'b10: begin
        r = '0;
        for (int k = 0; k < 4; k++) r[16*k +: 16] = hw(a, 4 - int'(sel[2*k +: 2]));
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] op, logic lft, logic [7:0] sel,
                       logic [63:0] a, logic [63:0] b, string req);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; take_left = lft; lane_sel = sel;
    src_a = a; src_b = b;
    exp_q.push_back(model(op, lft, sel, a, b));
    tag_q.push_back(req);
  endtask

  // idle cycle with changing data (R9: must not touch result)
  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; op_sel = 2'($urandom); take_left = 1'($urandom);
    lane_sel = 8'($urandom); src_a = {$urandom, $urandom}; src_b = {$urandom, $urandom};
  endtask

  always @(posedge clk) iv_d <= rst ? 1'b0 : in_valid;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      check("R2 valid", {63'd0, out_valid}, {63'd0, iv_d});
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected result", 64'd1, 64'd0);
        end else begin
          check(tag_q.pop_front(), result, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b, held;
    // R1: reset clears state even with a request pending
    in_valid = 1'b1; op_sel = 2'b01; src_a = '1; src_b = '1;
    repeat (3) @(negedge clk);
    check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 result", result, 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    idle();

    // R3..R6, R11: interleaves, random selector ignored
    a = 64'h1111_2222_3333_4444; b = 64'hAAAA_BBBB_CCCC_DDDD;
    drive(2'b00, 1'b1, 8'h00, a, b, "R3 half left");
    drive(2'b00, 1'b0, 8'h00, a, b, "R4 half right");
    drive(2'b01, 1'b1, 8'h00, a, b, "R5 word left");
    drive(2'b01, 1'b0, 8'h00, a, b, "R6 word right");
    for (int i = 0; i < 24; i++) begin
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      drive(2'b00, 1'b1, 8'($urandom), a, b, "R3 R11 half left");
      drive(2'b00, 1'b0, 8'($urandom), a, b, "R4 R11 half right");
      if (i % 3 == 0) idle();
      drive(2'b01, 1'b1, 8'($urandom), a, b, "R5 R11 word left");
      drive(2'b01, 1'b0, 8'($urandom), a, b, "R6 R11 word right");
    end

    // R7, R8: all 256 selectors, B and take_left varied
    for (int s = 0; s < 256; s++) begin
      a = {16'h0A00 + 16'(s), 16'h0B00 + 16'(s), 16'h0C00 + 16'(s), 16'h0D00 + 16'(s)};
      drive(2'b10, 1'(s), 8'(s), a, {$urandom, $urandom}, "R7 R8 permute");
      if (s % 17 == 0) idle();
    end

    // R10: unused code
    drive(2'b11, 1'b1, 8'hE4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0, "R10 zero");

    // R9: result held over idle cycles with changing inputs
    a = 64'hDEAD_BEEF_0123_4567; b = 64'h89AB_CDEF_FEDC_BA98;
    drive(2'b00, 1'b0, 8'h1B, a, b, "R4 before hold");
    held = model(2'b00, 1'b0, 8'h1B, a, b);
    repeat (4) idle();
    check("R9 hold", result, held);

    repeat (3) idle();
    check("R2 queue drained", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule